// File: doc/BRIEF.md
# Transmit Line-Word Framer with Idle Fill

This block turns one 32-bit parallel data word and a 2-bit word-type code into a 34-bit line word once per word clock, for a downstream serializer. The two overhead bits occupy the top of the line word and the data occupies the bottom. When the upstream source has nothing to send, it holds the transmit enable low and the framer emits a fixed idle word instead, so that the line is never left without a defined pattern.

In normal operation the word type is translated into an overhead code, and the all-zero overhead code is kept back for idle words. A bypass input hands the overhead bits to the user unchanged, for links where the far end reads them directly. When scrambling is on, data bits are combined with an additive keystream. Idle words are never scrambled.

A registered read-enable output tells the upstream FIFO it may give up a word. A stop indication from the far end's flow control forces that enable low on the next clock edge.

Top module: `tx_word_framer`

## Requirements
- R1: During reset and after it, until a word is accepted, `line_word` is the idle word: overhead bits [33:32] = 2'b00 and data bits [31:0] = 32'hBC95_6A3C. `rd_en` is low during reset, and the scrambler state is all ones.
- R2: A word is captured at a rising clock edge where `tx_en` is high. It appears on `line_word` from that edge onward: overhead in bits [33:32], data in bits [31:0].
- R3: At a rising edge where `tx_en` is low, `line_word` becomes the idle word. `tx_data`, `tx_type`, `bypass` and `scram_en` have no effect on the output, and the scrambler does not advance.
- R4: With `bypass` low, type codes map to overhead codes as follows: type 0 (data) gives 2'b01, type 1 (start) gives 2'b10, and type 2 (end) gives 2'b11.
- R5: With `bypass` low, type code 3 is reserved. It produces the idle word, just as if `tx_en` were low, and does not advance the scrambler.
- R6: With `bypass` high, `tx_type` is copied unchanged into overhead bits [33:32], including 2'b00. The data is handled as for any accepted word.
- R7: With `scram_en` low, the data bits of an accepted word equal `tx_data`.
- R8: With `scram_en` high, the data bits of an accepted word equal `tx_data` XOR a 32-bit keystream. The keystream comes from a 7-bit state s stepped 32 times. At each step b = s[6]^s[5] (polynomial x^7+x^6+1), s becomes {s[5:0], b}, and b fills the next data bit starting at bit 31. The stepped state is kept only for scrambled words.
- R9: The idle word is never scrambled. Its data bits are always 32'hBC95_6A3C.
- R10: `rd_en` is a register. At each rising edge out of reset it takes the inverse of `fc_stop`, so a stop seen at one edge drops `rd_en` by that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Capture data and type at this edge |
| tx_data | input | 32 | Parallel data word |
| tx_type | input | 2 | Word-type code, or raw overhead bits in bypass |
| bypass | input | 1 | Place `tx_type` directly in the overhead bits |
| scram_en | input | 1 | Scramble data bits of accepted words |
| fc_stop | input | 1 | Stop indication from the far end's flow control |
| rd_en | output | 1 | Upstream FIFO may supply a word |
| line_word | output | 34 | Framed line word: overhead [33:32], data [31:0] |

## Verification
If the scrambler state is wrong, the error does not show on idle words or unscrambled words. It shows in the data bits of the very next scrambled word, and every later scrambled word stays wrong, because the state only ever steps forward from its corrupted value. An error in overhead encoding or idle selection shows on `line_word` one edge after the offending input. A wrong flow-control register shows on `rd_en` at the edge after `fc_stop` changes. The bench sweeps every type, bypass and scramble combination, with the enable both on and off, over several data patterns, and tracks its own keystream state to catch skipped or extra advances.

// File: rtl/txf_pkg.sv
package txf_pkg;
  localparam int OVH_W = 2;

  typedef enum logic [OVH_W-1:0] {
    OVH_IDLE  = 2'b00,
    OVH_DATA  = 2'b01,
    OVH_START = 2'b10,
    OVH_END   = 2'b11
  } ovh_code_e;

  localparam logic [31:0] IDLE_FILL = 32'hBC95_6A3C;
endpackage

// File: rtl/txf_encoder.sv
module txf_encoder
  import txf_pkg::*;
(
  input  logic [OVH_W-1:0] tx_type,
  input  logic             bypass,
  output logic [OVH_W-1:0] ovh,
  output logic             type_idle
);
  always_comb begin
    type_idle = 1'b0;
    if (bypass) begin
      ovh = tx_type;
    end else begin
      unique case (tx_type)
        2'd0:    ovh = OVH_DATA;
        2'd1:    ovh = OVH_START;
        2'd2:    ovh = OVH_END;
        default: begin
          ovh       = OVH_IDLE;
          type_idle = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/txf_scrambler.sv
module txf_scrambler #(
  parameter int DATA_W = 32,
  parameter int LFSR_W = 7,
  parameter int TAP_A  = 6,
  parameter int TAP_B  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  output logic [DATA_W-1:0] keystream
);
  logic [LFSR_W-1:0] state;
  logic [LFSR_W-1:0] state_next;

  always_comb begin
    logic [LFSR_W-1:0] s;
    logic              b;
    s         = state;
    keystream = '0;
    for (int i = 0; i < DATA_W; i++) begin
      b                       = s[TAP_A] ^ s[TAP_B];
      keystream[DATA_W-1-i]   = b;
      s                       = {s[LFSR_W-2:0], b};
    end
    state_next = s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= '1;
    end else if (advance) begin
      state <= state_next;
    end
  end
endmodule

// File: rtl/txf_flow_ctrl.sv
module txf_flow_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic fc_stop,
  output logic rd_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en <= 1'b0;
    end else begin
      rd_en <= ~fc_stop;
    end
  end
endmodule

// File: rtl/tx_word_framer.sv
module tx_word_framer
  import txf_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          LFSR_W    = 7,
  parameter logic [31:0] IDLE_DATA = IDLE_FILL,
  localparam int         LINE_W    = DATA_W + OVH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [OVH_W-1:0]  tx_type,
  input  logic              bypass,
  input  logic              scram_en,
  input  logic              fc_stop,
  output logic              rd_en,
  output logic [LINE_W-1:0] line_word
);
  localparam logic [LINE_W-1:0] IDLE_WORD = {OVH_IDLE, IDLE_DATA[DATA_W-1:0]};

  logic [OVH_W-1:0]  ovh;
  logic              type_idle;
  logic [DATA_W-1:0] keystream;
  logic              word_accept;
  logic              scram_step;

  txf_encoder u_enc (
    .tx_type   (tx_type),
    .bypass    (bypass),
    .ovh       (ovh),
    .type_idle (type_idle)
  );

  assign word_accept = tx_en && !type_idle;
  assign scram_step  = word_accept && scram_en;

  txf_scrambler #(
    .DATA_W (DATA_W),
    .LFSR_W (LFSR_W),
    .TAP_A  (LFSR_W - 1),
    .TAP_B  (LFSR_W - 2)
  ) u_scr (
    .clk       (clk),
    .rst       (rst),
    .advance   (scram_step),
    .keystream (keystream)
  );

  txf_flow_ctrl u_fc (
    .clk     (clk),
    .rst     (rst),
    .fc_stop (fc_stop),
    .rd_en   (rd_en)
  );

  always_ff @(posedge clk) begin
    if (rst || !word_accept) begin
      line_word <= IDLE_WORD;
    end else begin
      line_word <= {ovh, scram_en ? (tx_data ^ keystream) : tx_data};
    end
  end
endmodule

// File: rtl/txf_checker.sv
module txf_checker #(
  parameter int          DATA_W    = 32,
  parameter logic [31:0] IDLE_DATA = 32'hBC95_6A3C
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_en,
  input logic [DATA_W-1:0] tx_data,
  input logic [1:0]        tx_type,
  input logic              bypass,
  input logic              scram_en,
  input logic              fc_stop,
  input logic              rd_en,
  input logic [DATA_W+1:0] line_word
);
  localparam logic [DATA_W+1:0] IDLE_W = {2'b00, IDLE_DATA[DATA_W-1:0]};

  assert_idle_when_off_R3: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> line_word == IDLE_W);

  assert_reserved_type_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_en && !bypass && tx_type == 2'd3) |=> line_word == IDLE_W);

  assert_type_map_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_en && !bypass && tx_type != 2'd3) |=>
      line_word[DATA_W+1:DATA_W] == $past(tx_type) + 2'd1);

  assert_bypass_raw_R6: assert property (@(posedge clk) disable iff (rst)
    (tx_en && bypass) |=> line_word[DATA_W+1:DATA_W] == $past(tx_type));

  assert_plain_data_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_en && !scram_en && (bypass || tx_type != 2'd3)) |=>
      line_word[DATA_W-1:0] == $past(tx_data));

  assert_stop_drops_rd_R10: assert property (@(posedge clk) disable iff (rst)
    fc_stop |=> !rd_en);

  assert_go_raises_rd_R10: assert property (@(posedge clk) disable iff (rst)
    !fc_stop |=> rd_en);
endmodule

bind tx_word_framer txf_checker #(
  .DATA_W    (DATA_W),
  .IDLE_DATA (IDLE_DATA)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tx_en     (tx_en),
  .tx_data   (tx_data),
  .tx_type   (tx_type),
  .bypass    (bypass),
  .scram_en  (scram_en),
  .fc_stop   (fc_stop),
  .rd_en     (rd_en),
  .line_word (line_word)
);

// File: tb/tb_tx_word_framer.sv
`timescale 1ns/1ps
module tb_tx_word_framer;
  localparam logic [33:0] IDLE_W = {2'b00, 32'hBC95_6A3C};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_en = 1'b0;
  logic [31:0] tx_data = '0;
  logic [1:0]  tx_type = '0;
  logic        bypass = 1'b0;
  logic        scram_en = 1'b0;
  logic        fc_stop = 1'b0;
  logic        rd_en;
  logic [33:0] line_word;

  int checks = 0;
  int fails  = 0;
  logic [6:0] mstate = 7'h7F;

  always #2 clk = ~clk;

  tx_word_framer dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .tx_data(tx_data), .tx_type(tx_type),
    .bypass(bypass), .scram_en(scram_en), .fc_stop(fc_stop),
    .rd_en(rd_en), .line_word(line_word)
  );

  task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] keys(input logic [6:0] st, output logic [6:0] nxt);
    logic [6:0] s = st;
    logic [31:0] k = '0;
    for (int i = 0; i < 32; i++) begin
      logic b = s[6] ^ s[5];
      k[31 - i] = b;
      s = {s[5:0], b};
    end
    nxt = s;
    return k;
  endfunction

  task automatic send(input logic en, input logic [31:0] d, input logic [1:0] t,
                      input logic byp, input logic scr, input string req);
    logic [33:0] exp;
    logic [6:0]  ns;
    logic [31:0] k;
    @(negedge clk);
    tx_en = en; tx_data = d; tx_type = t; bypass = byp; scram_en = scr;
    @(posedge clk);
    #1;
    if (!en || (!byp && t == 2'd3)) begin
      exp = IDLE_W;
    end else begin
      k = keys(mstate, ns);
      exp[33:32] = byp ? t : t + 2'd1;
      exp[31:0]  = scr ? (d ^ k) : d;
      if (scr) mstate = ns;
    end
    check(req, line_word, exp);
  endtask

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] pats [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'hA5C3_0F96};
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset word", line_word, IDLE_W);
    check("R1 reset rd_en", {33'd0, rd_en}, 34'd0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R1 idle after reset", line_word, IDLE_W);
    check("R10 rd_en up", {33'd0, rd_en}, 34'd1);
    // first scrambled word exposes the all-ones reset state (R1, R8)
    send(1'b1, 32'h0, 2'd0, 1'b0, 1'b1, "R1 R8 first keystream");
    for (int p = 0; p < 4; p++)
      for (int byp = 0; byp < 2; byp++)
        for (int scr = 0; scr < 2; scr++)
          for (int t = 0; t < 4; t++)
            for (int en = 1; en >= 0; en--)
              send(en[0], pats[p] ^ (t * 32'h0101_0101), t[1:0], byp[0], scr[0],
                   en == 0 ? "R3 disabled idle" :
                   (byp == 0 && t == 3) ? "R5 reserved type" :
                   byp == 1 ? "R6 bypass raw" :
                   scr == 1 ? "R8 R9 scrambled" : "R2 R4 R7 plain");
    // back-to-back scrambled words, idle in between must not step keystream (R9)
    send(1'b1, 32'hDEAD_BEEF, 2'd1, 1'b0, 1'b1, "R8 run");
    send(1'b0, 32'hDEAD_BEEF, 2'd1, 1'b0, 1'b1, "R9 idle unscrambled");
    send(1'b1, 32'hDEAD_BEEF, 2'd2, 1'b0, 1'b1, "R8 R9 resume");
    // flow control
    @(negedge clk); fc_stop = 1'b1;
    @(posedge clk); #1;
    check("R10 stop drops rd_en", {33'd0, rd_en}, 34'd0);
    @(posedge clk); #1;
    check("R10 held low", {33'd0, rd_en}, 34'd0);
    @(negedge clk); fc_stop = 1'b0;
    @(posedge clk); #1;
    check("R10 release", {33'd0, rd_en}, 34'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule